// File: doc/BRIEF.md
# Single-Shot Sampling Converter Sequencer

This block is the register front end for a multi-channel sampling converter. Software uses a word-addressed register port to choose a channel and a scale code. It then writes the control word with the enable bit, the resolution-mode bit, a repeat count and the run bit set. The block latches the channel, the scale and the mode at that moment. It then drives a one-cycle start strobe to the converter for each sample and waits for the converter's done strobe before the next one.

With a repeat count of N, the block takes N+1 samples. The 12-bit data register keeps the result of the last sample. When the sequence ends, the run bit clears by itself and a sticky raw completion flag sets. The flag can be polled whether or not interrupts are enabled. A masked copy of the flag, gated by an interrupt-enable bit, drives the interrupt output. Software clears the flag through a separate write-one-to-clear register before each new run. Clearing the enable bit stops the controller at once.

Top module: `adc_seq_regs`

## Requirements
- R1: After reset every register reads 0, and `irq` and `conv_start` are 0.
- R2: Control word layout at offset 0x00: bit 0 enable, bit 1 run (reads 1 while a sequence is active), bit 2 resolution mode, bits 7:4 repeat count. Channel config at 0x04: bits 4:0 channel, bits 10:8 scale. Bits that are not defined read as 0.
- R3: An address other than 0x00, 0x04, 0x4C, 0x50, 0x54, 0x58 and 0x5C reads as 0, and a write to it changes no register.
- R4: A control write with both run (bit 1) and enable (bit 0) set, made while idle, starts a sequence. Each sample begins with a one-cycle `conv_start`. While it is high, `conv_chan`, `conv_scale` and `conv_mode12` carry the values latched at the start. Configuration writes made during the sequence do not change them.
- R5: A repeat count of N gives exactly N+1 start strobes. The data register at 0x4C, bits 11:0, holds the result of the last sample.
- R6: When the last sample completes, bit 0 of the raw status register at 0x5C sets whether or not interrupts are enabled, and the run bit reads 0.
- R7: Bit 0 of the masked status at 0x58 equals raw status AND the interrupt-enable bit at 0x50 bit 0. `irq` equals the masked status.
- R8: Writing 1 to bit 0 of the clear register at 0x54 clears the raw flag, and writing 0 has no effect. If a clear and the final completion fall in the same cycle, the flag ends up set.
- R9: A run request written with the enable bit 0 is ignored: no start strobe occurs, the run bit reads 0 and the raw flag stays 0.
- R10: A control write with enable 0 during a sequence aborts it. No further start strobe occurs, the run bit reads 0 and the raw flag is not set.
- R11: A run request written while a sequence is active does not restart it or change its sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| conv_start | output | 1 | One-cycle sample start strobe |
| conv_chan | output | 5 | Latched channel |
| conv_scale | output | 3 | Latched scale code |
| conv_mode12 | output | 1 | Latched resolution mode |
| conv_done | input | 1 | Converter sample-complete strobe |
| conv_data | input | 12 | Converter result, valid with conv_done |
| irq | output | 1 | Masked completion interrupt |

## Verification
The raw completion flag has two writers that can act in the same cycle: the sequencer setting it on the final done strobe, and a software write-one-to-clear. The bench switches its converter model to manual control. It then raises `conv_done` in exactly the cycle that carries a clear write. It expects the flag to read 1 afterwards, with the data register holding the value it supplied. A second same-cycle pairing is also exercised: a run request arriving while the sequence is busy. Here the start-strobe count must match the originally latched repeat count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Byte offsets of the register words
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_CFG  = 'h04;
    localparam int OFS_DATA = 'h4C;
    localparam int OFS_IEN  = 'h50;
    localparam int OFS_ICLR = 'h54;
    localparam int OFS_ISTS = 'h58;
    localparam int OFS_IRAW = 'h5C;

    // Control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_RUN_BIT  = 1;
    localparam int CTRL_MODE_BIT = 2;
    localparam int CTRL_CNT_LSB  = 4;

    // Channel config field position
    localparam int CFG_SCALE_LSB = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_CFG  = 3'd2,
        SEL_DATA = 3'd3,
        SEL_IEN  = 3'd4,
        SEL_ICLR = 3'd5,
        SEL_ISTS = 3'd6,
        SEL_IRAW = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/adc_seq_decode.sv
module adc_seq_decode
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_lsb;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        sel = SEL_NONE;
        if (word == WORD_W'(OFS_CTRL / 4)) sel = SEL_CTRL;
        if (word == WORD_W'(OFS_CFG  / 4)) sel = SEL_CFG;
        if (word == WORD_W'(OFS_DATA / 4)) sel = SEL_DATA;
        if (word == WORD_W'(OFS_IEN  / 4)) sel = SEL_IEN;
        if (word == WORD_W'(OFS_ICLR / 4)) sel = SEL_ICLR;
        if (word == WORD_W'(OFS_ISTS / 4)) sel = SEL_ISTS;
        if (word == WORD_W'(OFS_IRAW / 4)) sel = SEL_IRAW;
    end

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CH_W    = 5,
    parameter int SCALE_W = 3,
    parameter int CNT_W   = 4,
    parameter int DATA_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    output logic               en,
    output logic               busy,
    output logic               mode12,
    output logic [CNT_W-1:0]   cnt,
    output logic [CH_W-1:0]    chan,
    output logic [SCALE_W-1:0] scale,
    output logic [DATA_W-1:0]  data,
    output logic               ien,
    output logic               raw,
    output logic               sts,
    output logic               conv_start,
    output logic [CH_W-1:0]    conv_chan,
    output logic [SCALE_W-1:0] conv_scale,
    output logic               conv_mode12,
    output logic [CNT_W-1:0]   left
);

    typedef struct packed {
        logic               en;
        logic               mode12;
        logic [CNT_W-1:0]   cnt;
        logic [CH_W-1:0]    chan;
        logic [SCALE_W-1:0] scale;
        logic [DATA_W-1:0]  data;
        logic               ien;
        logic               raw;
        seq_state_e         st;
        logic [CH_W-1:0]    l_chan;
        logic [SCALE_W-1:0] l_scale;
        logic               l_mode;
        logic [CNT_W-1:0]   left;
    } core_s;

    core_s q, d;
    logic  ctrl_wr;
    logic  stop_req;
    logic  run_req;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        d        = q;
        ctrl_wr  = wr_en && (sel == SEL_CTRL);
        stop_req = ctrl_wr && !wdata[CTRL_EN_BIT];
        run_req  = ctrl_wr && wdata[CTRL_EN_BIT] && wdata[CTRL_RUN_BIT];

        // software-visible fields
        if (ctrl_wr) begin
            d.en     = wdata[CTRL_EN_BIT];
            d.mode12 = wdata[CTRL_MODE_BIT];
            d.cnt    = wdata[CTRL_CNT_LSB +: CNT_W];
        end
        if (wr_en && sel == SEL_CFG) begin
            d.chan  = wdata[0 +: CH_W];
            d.scale = wdata[CFG_SCALE_LSB +: SCALE_W];
        end
        if (wr_en && sel == SEL_IEN) begin
            d.ien = wdata[0];
        end
        if (wr_en && sel == SEL_ICLR && wdata[0]) begin
            d.raw = 1'b0;
        end

        // sequencer; completion set below overrides a same-cycle clear
        if (q.st != SEQ_IDLE && stop_req) begin
            d.st = SEQ_IDLE;
        end else begin
            case (q.st)
                SEQ_IDLE: begin
                    if (run_req) begin
                        d.st      = SEQ_START;
                        d.l_chan  = q.chan;
                        d.l_scale = q.scale;
                        d.l_mode  = wdata[CTRL_MODE_BIT];
                        d.left    = wdata[CTRL_CNT_LSB +: CNT_W];
                    end
                end
                SEQ_START: begin
                    d.st = SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (conv_done) begin
                        d.data = conv_data;
                        if (q.left == '0) begin
                            d.st  = SEQ_IDLE;
                            d.raw = 1'b1;
                        end else begin
                            d.left = q.left - 1'b1;
                            d.st   = SEQ_START;
                        end
                    end
                end
                default: begin
                    d.st = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign en          = q.en;
    assign busy        = (q.st != SEQ_IDLE);
    assign mode12      = q.mode12;
    assign cnt         = q.cnt;
    assign chan        = q.chan;
    assign scale       = q.scale;
    assign data        = q.data;
    assign ien         = q.ien;
    assign raw         = q.raw;
    assign sts         = q.raw & q.ien;
    assign conv_start  = (q.st == SEQ_START);
    assign conv_chan   = q.l_chan;
    assign conv_scale  = q.l_scale;
    assign conv_mode12 = q.l_mode;
    assign left        = q.left;

endmodule

// File: rtl/adc_seq_rdmux.sv
module adc_seq_rdmux
    import adc_seq_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CH_W    = 5,
    parameter int SCALE_W = 3,
    parameter int CNT_W   = 4,
    parameter int DATA_W  = 12
) (
    input  logic               bus_sel,
    input  reg_sel_e           sel,
    input  logic               en,
    input  logic               busy,
    input  logic               mode12,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CH_W-1:0]    chan,
    input  logic [SCALE_W-1:0] scale,
    input  logic [DATA_W-1:0]  data,
    input  logic               ien,
    input  logic               sts,
    input  logic               raw,
    output logic [BUS_W-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (bus_sel) begin
            case (sel)
                SEL_CTRL: begin
                    rdata[CTRL_EN_BIT]                = en;
                    rdata[CTRL_RUN_BIT]               = busy;
                    rdata[CTRL_MODE_BIT]              = mode12;
                    rdata[CTRL_CNT_LSB +: CNT_W]      = cnt;
                end
                SEL_CFG: begin
                    rdata[0 +: CH_W]                  = chan;
                    rdata[CFG_SCALE_LSB +: SCALE_W]   = scale;
                end
                SEL_DATA: rdata[0 +: DATA_W] = data;
                SEL_IEN:  rdata[0]           = ien;
                SEL_ISTS: rdata[0]           = sts;
                SEL_IRAW: rdata[0]           = raw;
                default:  rdata              = '0;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BUS_W   = 32,
    parameter int CH_W    = 5,
    parameter int SCALE_W = 3,
    parameter int CNT_W   = 4,
    parameter int DATA_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               conv_start,
    output logic [CH_W-1:0]    conv_chan,
    output logic [SCALE_W-1:0] conv_scale,
    output logic               conv_mode12,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    output logic               irq
);

    reg_sel_e           sel;
    logic               wr_en;
    logic               en;
    logic               busy;
    logic               mode12;
    logic [CNT_W-1:0]   cnt;
    logic [CH_W-1:0]    chan;
    logic [SCALE_W-1:0] scale;
    logic [DATA_W-1:0]  data;
    logic               ien;
    logic               raw;
    logic               sts;
    logic [CNT_W-1:0]   left;

    assign wr_en = bus_sel && bus_wr;
    assign irq   = sts;

    adc_seq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    adc_seq_core #(
        .BUS_W(BUS_W), .CH_W(CH_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .sel         (sel),
        .wdata       (bus_wdata),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .en          (en),
        .busy        (busy),
        .mode12      (mode12),
        .cnt         (cnt),
        .chan        (chan),
        .scale       (scale),
        .data        (data),
        .ien         (ien),
        .raw         (raw),
        .sts         (sts),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_scale  (conv_scale),
        .conv_mode12 (conv_mode12),
        .left        (left)
    );

    adc_seq_rdmux #(
        .BUS_W(BUS_W), .CH_W(CH_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_rd (
        .bus_sel (bus_sel),
        .sel     (sel),
        .en      (en),
        .busy    (busy),
        .mode12  (mode12),
        .cnt     (cnt),
        .chan    (chan),
        .scale   (scale),
        .data    (data),
        .ien     (ien),
        .sts     (sts),
        .raw     (raw),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              conv_start,
    input logic [CH_W-1:0]   conv_chan,
    input logic              conv_done,
    input logic              irq,
    input logic              busy,
    input logic              raw,
    input logic              ien,
    input logic [CNT_W-1:0]  left
);
    localparam int WORD_W = ADDR_W - 2;

    logic ctrl_wr, clr_wr, waiting;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == WORD_W'(0));
    assign clr_wr  = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == WORD_W'('h54 / 4));
    assign waiting = busy && !conv_start;

    // R4: start strobe lasts exactly one cycle
    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4: latched channel does not move during a sequence
    a_r4_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(conv_chan));

    // R6: final done strobe sets the raw flag
    a_r6_raw_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && conv_done && left == '0 && !(ctrl_wr && !bus_wdata[0])) |=> raw);

    // R7: interrupt only with enable
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);

    // R8: clear without competing completion empties the flag
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata[0] && !(waiting && conv_done)) |=> !raw);

    // R9, R10: a control write with enable low leaves the sequencer idle
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[0]) |=> (!conv_start && !busy));

endmodule

bind adc_seq_regs adc_seq_checker #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CH_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .irq        (irq),
    .busy       (busy),
    .raw        (raw),
    .ien        (ien),
    .left       (left)
);

// File: tb/adc_seq_regs_test.sv
module adc_seq_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_DATA = 8'h4C, A_IEN = 8'h50,
                           A_ICLR = 8'h54, A_ISTS = 8'h58, A_IRAW = 8'h5C;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start, conv_mode12, conv_done, irq;
    logic [4:0]  conv_chan;
    logic [2:0]  conv_scale;
    logic [11:0] conv_data;

    // converter model state
    logic        manual = 0;
    logic        man_done = 0;
    logic [11:0] man_data = '0;
    logic        auto_done = 0;
    logic [11:0] auto_data = '0;
    int          lat = 0;
    int          n_starts = 0;
    int          n_bad = 0;
    int          base_starts = 0;
    int          exp_chan = 0, exp_scale = 0, exp_mode = 0;
    int          m_idx = 0;

    int checks = 0, errors = 0, cyc = 0;

    assign conv_done = manual ? man_done : auto_done;
    assign conv_data = manual ? man_data : auto_data;

    adc_seq_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_scale(conv_scale),
        .conv_mode12(conv_mode12), .conv_done(conv_done), .conv_data(conv_data),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] model_val(int ch, int sc, int idx, int md);
        return 12'((ch * 97 + sc * 131 + idx * 7 + md * 2048) & 12'hFFF);
    endfunction

    always @(negedge clk) begin
        auto_done = 1'b0;
        if (rst_n && conv_start) begin
            if (conv_chan !== 5'(exp_chan) || conv_scale !== 3'(exp_scale) ||
                conv_mode12 !== 1'(exp_mode)) n_bad++;
            m_idx = n_starts - base_starts;
            n_starts++;
            lat = LAT;
        end else if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                auto_done = 1'b1;
                auto_data = model_val(int'(conv_chan), int'(conv_scale), m_idx, int'(conv_mode12));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_raw(input string req);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 400; i++) begin
            rd(A_IRAW, v);
            if (v[0]) break;
        end
        chk(req, {31'd0, v[0]}, 32'd1);
    endtask

    task automatic do_run(input int ch, input int sc, input int cn, input int md, input int ie);
        logic [31:0] v;
        exp_chan = ch; exp_scale = sc; exp_mode = md;
        wr(A_CFG, 32'((sc << 8) | ch));
        wr(A_ICLR, 32'd1);
        base_starts = n_starts;
        wr(A_CTRL, 32'(1 | 2 | (md << 2) | (cn << 4)));
        wait_raw("R6 raw set on completion");
        chk("R5 start count is N+1", 32'(n_starts - base_starts), 32'(cn + 1));
        rd(A_DATA, v);
        chk("R5 data is last sample", v, 32'(model_val(ch, sc, cn, md)));
        rd(A_CTRL, v);
        chk("R6 run bit self-clears", {31'd0, v[1]}, 32'd0);
        chk("R4 latched chan/scale/mode at start", 32'(n_bad), 32'd0);
        rd(A_ISTS, v);
        chk("R7 masked status", {31'd0, v[0]}, 32'(ie));
        chk("R7 irq follows masked status", {31'd0, irq}, 32'(ie));
    endtask

    initial begin
        logic [31:0] v;
        v = '0;
        idle(3);
        rst_n = 1;
        idle(2);

        // R1: reset values
        begin
            logic [7:0] al [7] = '{A_CTRL, A_CFG, A_DATA, A_IEN, A_ICLR, A_ISTS, A_IRAW};
            for (int i = 0; i < 7; i++) begin
                rd(al[i], v);
                chk("R1 reset register value", v, 32'd0);
            end
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 conv_start after reset", {31'd0, conv_start}, 32'd0);

        // R2: field layout and readback
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd(A_CTRL, v);
        chk("R2 control readback", v, 32'h0000_00F5);
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v);
        chk("R2 config readback", v, 32'h0000_071F);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, v);
        chk("R2 enable readback", v, 32'd1);
        wr(A_IEN, 32'd0);

        // R3: unmapped addresses
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h7C, 32'h0000_0000);
        rd(8'h20, v);
        chk("R3 unmapped read", v, 32'd0);
        rd(8'h48, v);
        chk("R3 unmapped read near data", v, 32'd0);
        rd(A_CFG, v);
        chk("R3 config unchanged by unmapped write", v, 32'h0000_071F);
        rd(A_CTRL, v);
        chk("R3 control unchanged by unmapped write", v, 32'h0000_00F5);
        wr(A_CTRL, 32'd0);

        // R9: run with enable low
        base_starts = n_starts;
        wr(A_CTRL, 32'h0000_0002);
        idle(20);
        chk("R9 no start when disabled", 32'(n_starts - base_starts), 32'd0);
        rd(A_CTRL, v);
        chk("R9 run bit reads 0", {31'd0, v[1]}, 32'd0);
        rd(A_IRAW, v);
        chk("R9 raw stays 0", v, 32'd0);

        // R5/R4/R6/R7: repeat-count sweep, interrupts masked
        for (int cn = 0; cn < 16; cn++)
            do_run((cn * 7 + 3) % 32, cn % 8, cn, cn % 2, 0);
        // R4/R5: every channel, single sample
        for (int ch = 0; ch < 32; ch++)
            do_run(ch, (ch * 3) % 8, 0, (ch >> 1) % 2, 0);

        // R7/R8: interrupt enable and clear behaviour
        wr(A_IEN, 32'd1);
        do_run(11, 6, 1, 1, 1);
        wr(A_ICLR, 32'd0);
        rd(A_IRAW, v);
        chk("R8 writing 0 to clear has no effect", v, 32'd1);
        wr(A_IEN, 32'd0);
        chk("R7 irq drops with enable off", {31'd0, irq}, 32'd0);
        rd(A_ISTS, v);
        chk("R7 masked status with enable off", v, 32'd0);
        wr(A_IEN, 32'd1);
        chk("R7 irq returns with enable on", {31'd0, irq}, 32'd1);
        wr(A_ICLR, 32'd1);
        rd(A_IRAW, v);
        chk("R8 clear empties raw flag", v, 32'd0);
        chk("R8 irq low after clear", {31'd0, irq}, 32'd0);
        wr(A_IEN, 32'd0);

        // R8: clear and completion in the same cycle
        manual = 1;
        exp_chan = 5; exp_scale = 2; exp_mode = 1;
        wr(A_CFG, 32'h0000_0205);
        base_starts = n_starts;
        wr(A_CTRL, 32'h0000_0007);
        for (int i = 0; i < 50 && n_starts == base_starts; i++) @(negedge clk);
        idle(2);
        man_done = 1; man_data = 12'hABC;
        bus_sel = 1; bus_wr = 1; bus_addr = A_ICLR; bus_wdata = 32'd1;
        @(posedge clk);
        @(negedge clk);
        man_done = 0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        rd(A_IRAW, v);
        chk("R8 completion wins over same-cycle clear", v, 32'd1);
        rd(A_DATA, v);
        chk("R8 data captured in collision cycle", v, 32'h0000_0ABC);
        manual = 0;
        wr(A_ICLR, 32'd1);

        // R11/R4: run request and config change while busy
        exp_chan = 9; exp_scale = 4; exp_mode = 0;
        wr(A_CFG, 32'h0000_0409);
        base_starts = n_starts;
        wr(A_CTRL, 32'h0000_0023);
        wr(A_CFG, 32'h0000_0114);
        wr(A_CTRL, 32'h0000_0003);
        wait_raw("R11 sequence still completes");
        chk("R11 busy run request does not restart", 32'(n_starts - base_starts), 32'd3);
        chk("R4 config change during run not applied", 32'(n_bad), 32'd0);
        rd(A_DATA, v);
        chk("R11 data from original sequence", v, 32'(model_val(9, 4, 2, 0)));
        wr(A_ICLR, 32'd1);

        // R10: abort by clearing enable
        exp_chan = 20; exp_scale = 1; exp_mode = 0;
        base_starts = n_starts;
        wr(A_CTRL, 32'h0000_0033);
        for (int i = 0; i < 50 && n_starts == base_starts; i++) @(negedge clk);
        wr(A_CTRL, 32'd0);
        idle(40);
        chk("R10 no further start after abort", 32'(n_starts - base_starts), 32'd1);
        rd(A_CTRL, v);
        chk("R10 run bit reads 0 after abort", v, 32'd0);
        rd(A_IRAW, v);
        chk("R10 raw not set after abort", v, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule